// File: doc/BRIEF.md
# Receive Character FIFO with Companion Status

This block sits between a serial receiver and a host. Each time the receiver finishes a character, it offers the byte together with three error flags. The block stores the byte in a data queue and stores a status byte in a second queue that moves in step with the first. The host can look at the status of the oldest character without consuming it. It then fetches the character, and that fetch retires the data entry and the status entry together.

The queue is always active and has no enable control. The `DEPTH` parameter sets the number of entries; any value of 1 or more works, and it need not be a power of two. A receiver push that arrives while every entry is occupied is not stored. Instead, the status of the most recently stored character is marked with an overrun flag. The block has one level output, high while any character is waiting. That output also drives the interrupt request and the DMA request.

Top module: `rx_char_fifo`

## Requirements
- R1: A push stores `wr_char` and, in the matching status entry, the byte {4'b0000, `wr_eof`, overrun=0, `wr_frm_err`, `wr_par_err`}: bit 0 is parity error, bit 1 is framing error, bit 2 is overrun, bit 3 is end of frame, and bits 7:4 are zero.
- R2: A pulse on `rd_char` while the queue is not empty loads the oldest character into `char_q` in the next cycle and retires both the oldest data entry and the oldest status entry.
- R3: A pulse on `rd_stat` loads the status of the oldest entry into `stat_q` in the next cycle and retires nothing. When the queue is empty, `stat_q` becomes 0x00.
- R4: A push while all `DEPTH` entries are occupied, with no retiring read in the same cycle, leaves the stored characters unchanged. It sets bit 2 of the status of the newest stored entry.
- R5: A push and a retiring read in the same cycle on a full queue are both carried out, and the new character is stored.
- R6: A pulse on `rd_char` while the queue is empty leaves `char_q` at its previous value and leaves the occupancy unchanged.
- R7: `char_avail`, `irq` and `dma_req` are high exactly when at least one character is stored.
- R8: With `rst` high at a clock edge, both queues are emptied, all stored status is cleared, and `char_q` and `stat_q` become 0x00.
- R9: Characters come out in arrival order, including when the entry indices wrap past `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Receiver offers a character this cycle |
| wr_char | input | 8 | Received character |
| wr_par_err | input | 1 | Parity error for this character |
| wr_frm_err | input | 1 | Framing error for this character |
| wr_eof | input | 1 | Character ends a frame |
| rd_char | input | 1 | Host data read strobe; retires the oldest entry |
| rd_stat | input | 1 | Host status read strobe; retires nothing |
| char_q | output | 8 | Last character fetched by the host |
| stat_q | output | 8 | Last status byte fetched by the host |
| char_avail | output | 1 | At least one character is stored |
| irq | output | 1 | Interrupt request, follows `char_avail` |
| dma_req | output | 1 | DMA request, follows `char_avail` |

## Verification
The assertions assume that every strobe is sampled as a clean level at the rising clock edge. They also assume that the first edge after power-up falls inside reset, so the occupancy history used by the count checks begins at zero. The stimulus follows these rules. It changes every input one time unit after a rising edge. It holds `rst` high for the first edges. It mixes pushes, status reads and data reads freely within those rules, and that includes same-cycle combinations on an empty queue and on a full queue.

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_char,
  input  logic       wr_par_err,
  input  logic       wr_frm_err,
  input  logic       wr_eof,
  input  logic       rd_char,
  input  logic       rd_stat,
  output logic [7:0] char_q,
  output logic [7:0] stat_q,
  output logic       char_avail,
  output logic       irq,
  output logic       dma_req
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    dmem [DEPTH];
  logic [7:0]    smem [DEPTH];
  logic [PW-1:0] wp, rp, newest;
  logic [CW-1:0] cnt;

  wire empty  = (cnt == '0);
  wire full   = (cnt == FULL);
  wire do_pop = rd_char && !empty;
  wire do_wr  = wr_en && (!full || do_pop);
  wire ovr    = wr_en && full && !do_pop;

  assign newest     = (wp == '0) ? LAST : wp - 1'b1;
  assign char_avail = !empty;
  assign irq        = char_avail;
  assign dma_req    = char_avail;

  always_ff @(posedge clk)
    if (do_wr) dmem[wp] <= wr_char;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      char_q <= '0;
      stat_q <= '0;
      for (int i = 0; i < DEPTH; i++) smem[i] <= '0;
    end else begin
      if (do_wr) begin
        smem[wp] <= {4'b0000, wr_eof, 1'b0, wr_frm_err, wr_par_err};
        wp       <= (wp == LAST) ? '0 : wp + 1'b1;
      end
      if (ovr) smem[newest][2] <= 1'b1;
      if (do_pop) begin
        char_q <= dmem[rp];
        rp     <= (rp == LAST) ? '0 : rp + 1'b1;
      end
      if (rd_stat) stat_q <= empty ? 8'h00 : smem[rp];
      cnt <= cnt + CW'(do_wr) - CW'(do_pop);
    end
  end

  a_r8_reset_empties: assert property (@(posedge clk)
    rst |=> (!char_avail && char_q == 8'h00 && stat_q == 8'h00));

  a_r4_full_no_grow: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_char) |=> (cnt == $past(cnt) && char_avail));

  a_r6_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_char && !wr_en) |=> ($stable(char_q) && !char_avail));

  a_r3_stat_no_pop: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !rd_char && !wr_en) |=> $stable(cnt));

  a_r2_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
    (rd_char && !empty && !wr_en) |=> (cnt == $past(cnt) - 1'b1));

  a_r5_full_swap: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && rd_char) |=> (cnt == FULL));

  a_r7_req_match: assert property (@(posedge clk) disable iff (rst)
    (irq == char_avail) && (dma_req == char_avail));

  a_r9_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
endmodule

// File: tb/sim_rx_char_fifo.sv
module sim_rx_char_fifo;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 8;
  localparam int NV     = 11;
  // {wr_en, char, eof, frm, par, rd_char, rd_stat, exp_avail, exp_char, exp_stat}
  localparam logic [30:0] VEC [NV] = '{
    {1'b1, 8'hA1, 3'b000, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00},
    {1'b1, 8'hB2, 3'b001, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b1, 8'hA1, 8'h00},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b1, 8'hA1, 8'h01},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 1'b0, 8'hB2, 8'h01},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 8'hB2, 8'h01},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0, 8'hB2, 8'h00},
    {1'b1, 8'hC3, 3'b110, 1'b1, 1'b0, 1'b1, 8'hB2, 8'h00},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b1, 8'hB2, 8'h0A},
    {1'b1, 8'hD4, 3'b000, 1'b1, 1'b0, 1'b1, 8'hC3, 8'h0A},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 1'b0, 8'hD4, 8'h00}
  };

  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_par_err = 0, wr_frm_err = 0, wr_eof = 0, rd_char = 0, rd_stat = 0;
  logic [7:0] wr_char = 0;
  logic [7:0] char_q, stat_q;
  logic char_avail, irq, dma_req;
  int checks = 0, errors = 0;
  bit done = 0;

  rx_char_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char),
    .wr_par_err(wr_par_err), .wr_frm_err(wr_frm_err), .wr_eof(wr_eof),
    .rd_char(rd_char), .rd_stat(rd_stat), .char_q(char_q), .stat_q(stat_q),
    .char_avail(char_avail), .irq(irq), .dma_req(dma_req));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic [2:0] st,
                      input logic rc, input logic rs);
    wr_en = w; wr_char = d; {wr_eof, wr_frm_err, wr_par_err} = st;
    rd_char = rc; rd_stat = rs;
    @(posedge clk); #1;
    wr_en = 0; rd_char = 0; rd_stat = 0; {wr_eof, wr_frm_err, wr_par_err} = 3'b000;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R8 reset avail", {5'b0, char_avail, irq, dma_req}, 8'h00);
    chk("R8 reset char", char_q, 8'h00);
    chk("R8 reset stat", stat_q, 8'h00);

    // R1 R2 R3 R6 R7 mixed patterns
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][30], VEC[i][29:22], VEC[i][21:19], VEC[i][18], VEC[i][17]);
      chk($sformatf("R7 vec%0d avail", i), {7'b0, char_avail}, {7'b0, VEC[i][16]});
      chk($sformatf("R2 vec%0d char", i), char_q, VEC[i][15:8]);
      chk($sformatf("R1 R3 vec%0d stat", i), stat_q, VEC[i][7:0]);
    end

    // R4: fill, then push while full
    for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 3'b000, 0, 0);
    step(1, 8'hEE, 3'b111, 0, 0);
    step(0, 0, 3'b000, 0, 1);
    chk("R4 head status untouched", stat_q, 8'h00);
    chk("R7 full irq", {6'b0, irq, dma_req}, 8'h03);
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 3'b000, 0, 1);
      chk($sformatf("R4 stat idx%0d", i), stat_q, (i == DEPTH-1) ? 8'h04 : 8'h00);
      step(0, 0, 3'b000, 1, 0);
      chk($sformatf("R4 R9 char idx%0d", i), char_q, 8'h10 + 8'(i));
    end
    chk("R4 drained", {7'b0, char_avail}, 8'h00);

    // R5: push and read together on a full queue; R9 across wrap
    for (int i = 0; i < DEPTH; i++) step(1, 8'h40 + 8'(i), 3'b000, 0, 0);
    step(1, 8'h5A, 3'b010, 1, 0);
    chk("R5 swap char", char_q, 8'h40);
    for (int i = 1; i < DEPTH; i++) step(0, 0, 3'b000, 1, 0);
    chk("R9 wrap last old", char_q, 8'h40 + 8'(DEPTH-1));
    step(0, 0, 3'b000, 0, 1);
    chk("R5 new stat", stat_q, 8'h02);
    step(0, 0, 3'b000, 1, 0);
    chk("R5 new char", char_q, 8'h5A);
    chk("R7 empty again", {7'b0, char_avail}, 8'h00);

    // R6: empty read does not disturb later occupancy
    step(0, 0, 3'b000, 1, 0);
    step(1, 8'h77, 3'b000, 0, 0);
    step(0, 0, 3'b000, 1, 0);
    chk("R6 count intact", {char_q[7:1], char_avail}, {7'h3B, 1'b0});

    // R8: reset with entries held
    step(1, 8'h99, 3'b001, 0, 0);
    step(1, 8'h98, 3'b000, 0, 1);
    rst = 1; @(posedge clk); #1 rst = 0;
    chk("R8 mid reset avail", {7'b0, char_avail}, 8'h00);
    chk("R8 mid reset char", char_q, 8'h00);
    step(0, 0, 3'b000, 0, 1);
    chk("R8 mid reset stat", stat_q, 8'h00);
    step(1, 8'h31, 3'b000, 0, 1);
    step(0, 0, 3'b000, 1, 1);
    chk("R8 fresh char", char_q, 8'h31);
    chk("R8 fresh stat", stat_q, 8'h00);

    finish_run();
  end
endmodule